// File: doc/BRIEF.md
# Wake Event Indicator Output Controller

This block turns a wake-up detection into a signal on an external power-management pin. A small control register holds three bits. The enable bit lets the pin respond. The polarity bit chooses whether the pin is active high or active low. The style bit chooses between a pulse of fixed length and a level that is held. A strap input selects open-drain operation. In that mode the pin drives only low and is released when inactive, so it is modelled as data fixed at 0 with an output-enable.

Each wake event also sets a status flag, which is presented as an internal interrupt. The enable bit has no effect on this flag. The host clears the flag with a status-clear strobe, and that strobe also removes the pin indication.

A ready bit reports that the device has stabilized after power-up or wake. It is read-only, appears in the control register, and is set one cycle after the stabilization-done input rises. The configuration register and the control register can always be accessed. Access to any other address counts as permitted only once the ready bit is set.

Top module: `wake_pin_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable, polarity, style and ready bits read 0, evt_irq is 0, and with od_strap low the pin is inactive (pin_o=1, pin_oe=1).
- R2: With enable set and the style bit clear (level), the pin becomes active on the clock edge that samples wake_evt high. It stays active until it is deactivated.
- R3: With enable and the style bit set (pulse), a wake event makes the pin active for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_MS cycles. The pin then returns inactive while evt_irq stays 1.
- R4: A wake event that arrives while a pulse is running neither restarts nor lengthens that pulse.
- R5: The pin is deactivated by sts_clr, when no wake_evt occurs in the same cycle, or by clearing the enable bit. Either action also ends a running pulse.
- R6: When od_strap is low, pin_oe is 1. With the polarity bit set, the active pin level is 1. With the polarity bit clear, the active pin level is 0.
- R7: When od_strap is high, pin_o is always 0 and pin_oe equals the active state, whatever the polarity bit holds.
- R8: A wake event sets evt_irq on the next edge even when the enable bit is 0. In that case the pin stays inactive.
- R9: sts_clr clears evt_irq. If wake_evt is high in the same cycle, the wake event takes priority.
- R10: ready rises on the edge that samples stab_done high after it was low. It then stays 1 until reset and is readable at reg_rdata bit 3. The bit cannot be written.
- R11: acc_ok is 1 for reg_addr equal to CFG_ADDR or CTL_ADDR at all times. For any other address it equals ready.
- R12: A write with reg_addr=CTL_ADDR loads reg_wdata bit 0 as the enable, bit 1 as the polarity and bit 2 as the style. With CTL_ADDR selected, reg_rdata returns {ready, style, polarity, enable}. For other addresses reg_rdata reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_evt | input | 1 | Wake-up event detected (one strobe per event) |
| sts_clr | input | 1 | Host strobe that clears the wake status |
| stab_done | input | 1 | Device stabilization complete |
| od_strap | input | 1 | Open-drain pin mode strap |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 3 | Control write data |
| reg_rdata | output | 4 | Control read data |
| pin_o | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output-enable |
| evt_irq | output | 1 | Internal wake event interrupt flag |
| ready | output | 1 | Device ready status |
| acc_ok | output | 1 | Access to reg_addr is permitted |

## Verification
The bench builds the block with CLK_HZ=20000 and PULSE_MS=1, which gives PULSE_CYC=20. With that value a whole pulse, and a wake event arriving partway through one, can be counted cycle by cycle. The default timing would need 2.5 million cycles per pulse. The address parameters keep their default values, so both exempt addresses and an ordinary address are exercised before and after the ready bit is set.

// File: rtl/wake_pin_ctrl.sv
module wake_pin_ctrl #(
  parameter int CLK_HZ = 50_000_000,
  parameter int PULSE_MS = 50,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h54,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_evt,
  input  logic              sts_clr,
  input  logic              stab_done,
  input  logic              od_strap,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [2:0]        reg_wdata,
  output logic [3:0]        reg_rdata,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              evt_irq,
  output logic              ready,
  output logic              acc_ok
);
  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_MS;
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC);

  logic en_q, pol_q, mode_q, sts_q, stab_q, rdy_q;
  logic [CW-1:0] cnt_q;

  wire ctl_sel = (reg_addr == CTL_ADDR);
  wire cfg_sel = (reg_addr == CFG_ADDR);
  wire busy    = (cnt_q != '0);
  wire kill    = (sts_clr & ~wake_evt) | ~en_q;
  wire start   = wake_evt & en_q & mode_q & ~busy;
  wire active  = en_q & sts_q & (~mode_q | busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (reg_wr && ctl_sel) begin
      en_q   <= reg_wdata[0];
      pol_q  <= reg_wdata[1];
      mode_q <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= wake_evt | (sts_q & ~sts_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (kill)  cnt_q <= '0;
    else if (start) cnt_q <= CNT_LOAD;
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stab_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      stab_q <= stab_done;
      rdy_q  <= rdy_q | (stab_done & ~stab_q);
    end
  end

  assign pin_o     = od_strap ? 1'b0 : ~(active ^ pol_q);
  assign pin_oe    = od_strap ? active : 1'b1;
  assign evt_irq   = sts_q;
  assign ready     = rdy_q;
  assign acc_ok    = rdy_q | ctl_sel | cfg_sel;
  assign reg_rdata = ctl_sel ? {rdy_q, mode_q, pol_q, en_q} : 4'b0;
endmodule

module wake_pin_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h54,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h84
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_evt,
  input logic              sts_clr,
  input logic              stab_done,
  input logic              od_strap,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              pin_o,
  input logic              pin_oe,
  input logic              evt_irq,
  input logic              ready,
  input logic              acc_ok,
  input logic              pol_q
);
  wire seen_act = od_strap ? pin_oe : (pin_o == pol_q);

  p_od_low_r7: assert property (@(posedge clk) disable iff (!rst_n) od_strap |-> !pin_o);
  p_pp_drive_r6: assert property (@(posedge clk) disable iff (!rst_n) !od_strap |-> pin_oe);
  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n) wake_evt |=> evt_irq);
  p_clr_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !wake_evt) |=> (!seen_act && !evt_irq));
  p_rdy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n) $rose(stab_done) |=> ready);
  p_rdy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) ready |=> ready);
  p_acc_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && reg_addr != CFG_ADDR && reg_addr != CTL_ADDR) |-> !acc_ok);
endmodule

bind wake_pin_ctrl wake_pin_ctrl_chk #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .sts_clr(sts_clr), .stab_done(stab_done),
  .od_strap(od_strap), .reg_addr(reg_addr), .pin_o(pin_o), .pin_oe(pin_oe),
  .evt_irq(evt_irq), .ready(ready), .acc_ok(acc_ok), .pol_q(pol_q)
);

// File: tb/wake_pin_ctrl_test.sv
module wake_pin_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPULSE = 20;
  localparam logic [7:0] CFG_A = 8'h54;
  localparam logic [7:0] CTL_A = 8'h84;
  localparam logic [7:0] OTHER_A = 8'h10;
  // {od, pol, idle_o, idle_oe, act_o, act_oe}
  localparam logic [5:0] VEC [4] = '{6'b00_11_01, 6'b01_01_11, 6'b10_00_01, 6'b11_00_01};

  logic clk = 1'b0, rst_n = 1'b0, wake_evt = 1'b0, sts_clr = 1'b0, stab_done = 1'b0;
  logic od_strap = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = CTL_A;
  logic [2:0] reg_wdata = 3'b0;
  logic [3:0] reg_rdata;
  logic pin_o, pin_oe, evt_irq, ready, acc_ok;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_pin_ctrl #(.CLK_HZ(20000), .PULSE_MS(1)) uut (
    .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .sts_clr(sts_clr), .stab_done(stab_done),
    .od_strap(od_strap), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_o(pin_o), .pin_oe(pin_oe), .evt_irq(evt_irq),
    .ready(ready), .acc_ok(acc_ok));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [2:0] d);
    reg_addr = CTL_A; reg_wdata = d; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
  endtask

  task automatic wake();
    wake_evt = 1'b1; tick(); wake_evt = 1'b0;
  endtask

  task automatic clr();
    sts_clr = 1'b1; tick(); sts_clr = 1'b0;
  endtask

  function automatic bit pp_active();
    return pin_o == 1'b0;
  endfunction

  initial begin
    int n;
    @(negedge clk); tick(); tick();
    rst_n = 1'b1; tick();
    chk("R1 ctl", reg_rdata, 0);
    chk("R1 pin_o", pin_o, 1);
    chk("R1 pin_oe", pin_oe, 1);
    chk("R1 irq", evt_irq, 0);
    chk("R1 ready", ready, 0);

    foreach (VEC[i]) begin
      od_strap = VEC[i][5];
      wr_ctl({1'b0, VEC[i][4], 1'b1});
      chk("R6/R7 idle o", pin_o, VEC[i][3]);
      chk("R6/R7 idle oe", pin_oe, VEC[i][2]);
      wake();
      chk("R2 act o", pin_o, VEC[i][1]);
      chk("R2 act oe", pin_oe, VEC[i][0]);
      repeat (3) tick();
      chk("R2 held o", pin_o, VEC[i][1]);
      clr();
      chk("R5 cleared o", pin_o, VEC[i][3]);
      chk("R5 cleared oe", pin_oe, VEC[i][2]);
    end
    od_strap = 1'b0;

    wr_ctl(3'b101);
    wake();
    n = 0;
    while (pp_active() && n < 100) begin n++; tick(); end
    chk("R3 pulse length", n, NPULSE);
    chk("R3 irq after pulse", evt_irq, 1);
    clr();

    wake();
    repeat (5) tick();
    wake();
    n = 0;
    while (pp_active() && n < 100) begin n++; tick(); end
    chk("R4 no restart", n, NPULSE - 6);
    clr();

    wake(); repeat (3) tick();
    clr();
    chk("R5 pulse ended by clear", pin_o, 1);
    wr_ctl(3'b101);
    chk("R5 no resume", pin_o, 1);

    wr_ctl(3'b001);
    wake();
    chk("R5 level active", pin_o, 0);
    wr_ctl(3'b000);
    chk("R5 enable off", pin_o, 1);
    chk("R8 irq kept", evt_irq, 1);
    clr();

    wake();
    chk("R8 irq without enable", evt_irq, 1);
    chk("R8 pin masked", pin_o, 1);
    sts_clr = 1'b1; wake_evt = 1'b1; tick(); wake_evt = 1'b0; sts_clr = 1'b0;
    chk("R9 wake beats clear", evt_irq, 1);
    clr();
    chk("R9 irq cleared", evt_irq, 0);

    reg_addr = OTHER_A; #1;
    chk("R11 blocked before ready", acc_ok, 0);
    chk("R12 other addr reads 0", reg_rdata, 0);
    reg_addr = CFG_A; #1;
    chk("R11 cfg exempt", acc_ok, 1);
    reg_addr = CTL_A; #1;
    chk("R11 ctl exempt", acc_ok, 1);

    stab_done = 1'b1; #1;
    chk("R10 not yet ready", ready, 0);
    tick();
    chk("R10 ready set", ready, 1);
    chk("R10 ready readback", reg_rdata[3], 1);
    stab_done = 1'b0; tick();
    chk("R10 ready sticky", ready, 1);
    reg_addr = OTHER_A; #1;
    chk("R11 allowed after ready", acc_ok, 1);

    wr_ctl(3'b110);
    chk("R12 readback", reg_rdata, 4'b1110);
    wr_ctl(3'b000);
    chk("R10 ready not writable", reg_rdata, 4'b1000);

    rst_n = 1'b0; tick(); rst_n = 1'b1;
    chk("R1 ready cleared by reset", ready, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule